// File: doc/BRIEF.md
# Charge-Sharing Row Operation Sequencer

This block sits on the controller side of a DDR3-style memory. It takes a single request to copy one row into another, or to form the bitwise AND or OR of two rows. It turns that request into a raw stream of ACTIVATE, PRECHARGE and NOP commands, one per clock. The gaps between commands are set on purpose well below the legal row-active and precharge times. As a result, the bit-lines of one opened row are still charged when the next row opens. The row that opens second then takes on the data of the first. If three rows are open together, each bit settles to the majority of the three.

A logic request never works on the user rows themselves. It first copies operand A, operand B and a constant row into the three compute rows at the bottom of the subarray. The constant row holds all zeros for AND and all ones for OR. It then opens the three compute rows together and copies compute row 0 to the destination. Before any command is issued, the block checks the request. All rows must lie in one subarray, the operation code must be defined, and no row involved may appear in a small table of rows known to be faulty. A request that fails these checks is rejected with an error pulse.

Top module: `imc_cmd_seq`

## Requirements
- R1: Out of reset `cmd_o` is NOP, and `busy`, `done` and `err` are 0 while `req_ready` is 1. Command codes are NOP=0, ACT=1, PRE=2. On NOP cycles `cmd_bank` and `cmd_row` are 0. On PRE cycles `cmd_row` is 0 and `cmd_bank` is the request bank.
- R2: A copy (op 0) issues ACT(source) in the first cycle after the handshake. It follows with ras NOPs, PRE, rp NOPs, ACT(destination), close NOPs, PRE and close NOPs.
- R3: The three tick counts are captured at the handshake, so later changes to them have no effect on a running request. A count of 0 places the next command in the very next cycle.
- R4: AND (op 1) runs five copy-shaped steps, each with the gap pattern of R2. The steps are: A→C0, B→C1, Z→C2, the triple step, then C0→destination. With S the subarray base, C0, C1 and C2 are S+0, S+1 and S+2, and Z is S+3.
- R5: OR (op 2) follows the AND sequence but uses the all-ones row at S+4 in place of Z.
- R6: The triple step issues ACT(C1), then PRE after ras NOPs, then ACT(C2) after rp NOPs. It then closes with the same pattern as a copy.
- R7: A request fails if the subarray of any user row differs from that of the destination. The subarray is the row address divided by the rows per subarray. Only source A and the destination count for a copy. A failed request gives a one-cycle `err` in the cycle after the handshake and issues no commands.
- R8: A request is rejected as in R7 if any row it touches matches a valid table entry with the same bank. For a copy this means source and destination. For AND and OR it also covers C0 to C2 and the constant row. Table entries written with the valid bit at 0 are ignored.
- R9: `busy` is high from the first command through the cycle in which `done` pulses. `done` pulses for one cycle right after the last wait. `req_ready` is low while `busy` is high, and requests offered then are ignored.
- R10: Operation code 3 is rejected as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_op | input | 2 | 0 copy, 1 AND, 2 OR, 3 reserved |
| req_bank | input | BANK_W | Bank of all rows |
| req_src_a | input | ROW_W | Source / operand A row |
| req_src_b | input | ROW_W | Operand B row (logic ops) |
| req_dst | input | ROW_W | Destination row |
| cfg_ras_ticks | input | TICK_W | NOPs after the opening ACT |
| cfg_rp_ticks | input | TICK_W | NOPs after the interrupting PRE |
| cfg_close_ticks | input | TICK_W | NOPs after the second ACT and the closing PRE |
| tbl_we | input | 1 | Faulty-row table write strobe |
| tbl_idx | input | TBL_IDX_W | Table entry index |
| tbl_bank | input | BANK_W | Entry bank |
| tbl_row | input | ROW_W | Entry row |
| tbl_vld | input | 1 | Entry valid bit |
| cmd_o | output | 2 | Command code |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The hardest case to reach from the ports is a rejection caused only by an internal row. An AND request can have clean user rows and still touch a listed compute row or constant row. The stimulus writes the table so that only the compute row at S+1, or the all-ones row, is listed. It then sends an otherwise legal AND and an otherwise legal OR in that subarray. A third case writes an entry with its valid bit cleared and confirms that a matching copy still runs. A further case changes the tick counts and offers a second request while a sequence is under way, so that only the trace can show whether the captured values held.

// File: rtl/imc_pkg.sv
package imc_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_PRE = 2'd2
  } cmd_e;

  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_AND  = 2'd1,
    OP_OR   = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  // offsets inside a subarray
  localparam int ZERO_OFS = 3;
  localparam int ONES_OFS = 4;
  // rows checked against the faulty-row table
  localparam int NQ = 7;
endpackage

// File: rtl/imc_badrow_tbl.sv
module imc_badrow_tbl #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  parameter int DEPTH  = 8,
  parameter int NQ     = 7,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [BANK_W-1:0]          wr_bank,
  input  logic [ROW_W-1:0]           wr_row,
  input  logic                       wr_vld,
  input  logic [BANK_W-1:0]          q_bank,
  input  logic [NQ-1:0][ROW_W-1:0]   q_rows,
  input  logic [NQ-1:0]              q_mask,
  output logic                       hit
);
  logic [DEPTH-1:0] ent_hit;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic              vld_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic              we;

    assign we = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else if (we) vld_q <= wr_vld;
    end

    always_ff @(posedge clk) begin
      if (we) begin
        bank_q <= wr_bank;
        row_q  <= wr_row;
      end
    end

    always_comb begin
      ent_hit[e] = 1'b0;
      for (int q = 0; q < NQ; q++) begin
        if (vld_q && q_mask[q] && (bank_q == q_bank) && (row_q == q_rows[q]))
          ent_hit[e] = 1'b1;
      end
    end
  end

  assign hit = |ent_hit;
endmodule

// File: rtl/imc_req_check.sv
module imc_req_check
  import imc_pkg::*;
#(
  parameter int ROW_W   = 16,
  parameter int SA_BITS = 9
) (
  input  logic [1:0]                 op,
  input  logic [ROW_W-1:0]           src_a,
  input  logic [ROW_W-1:0]           src_b,
  input  logic [ROW_W-1:0]           dst,
  output logic [NQ-1:0][ROW_W-1:0]   q_rows,
  output logic [NQ-1:0]              q_mask,
  output logic                       shape_ok
);
  localparam int SA_W = ROW_W - SA_BITS;

  logic [SA_W-1:0] sa_a, sa_b, sa_d;
  logic            is_logic;

  assign sa_a = src_a[ROW_W-1:SA_BITS];
  assign sa_b = src_b[ROW_W-1:SA_BITS];
  assign sa_d = dst[ROW_W-1:SA_BITS];
  assign is_logic = (op == OP_AND) || (op == OP_OR);

  always_comb begin
    q_rows[0] = src_a;
    q_rows[1] = src_b;
    q_rows[2] = dst;
    q_rows[3] = {sa_d, SA_BITS'(0)};
    q_rows[4] = {sa_d, SA_BITS'(1)};
    q_rows[5] = {sa_d, SA_BITS'(2)};
    q_rows[6] = (op == OP_OR) ? {sa_d, SA_BITS'(ONES_OFS)} : {sa_d, SA_BITS'(ZERO_OFS)};
    q_mask    = is_logic ? {NQ{1'b1}} : NQ'(7'b0000101);
    shape_ok  = (op != OP_RSVD) && (sa_a == sa_d) && (!is_logic || (sa_b == sa_d));
  end
endmodule

// File: rtl/imc_seq_fsm.sv
module imc_seq_fsm
  import imc_pkg::*;
#(
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 16,
  parameter int SA_BITS = 9,
  parameter int TICK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              reject,
  input  logic [1:0]        op_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  src_a_i,
  input  logic [ROW_W-1:0]  src_b_i,
  input  logic [ROW_W-1:0]  dst_i,
  input  logic [TICK_W-1:0] ras_i,
  input  logic [TICK_W-1:0] rp_i,
  input  logic [TICK_W-1:0] close_i,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              idle
);
  localparam int SA_W = ROW_W - SA_BITS;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_WAIT, S_DONE} st_e;

  st_e               state_q, state_d;
  logic [2:0]        step_q, step_d;
  logic [1:0]        slot_q, slot_d;
  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic              err_q;

  op_e               op_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  a_q, b_q, d_q;
  logic [TICK_W-1:0] ras_q, rp_q, close_q;

  logic [SA_W-1:0]   sa;
  logic [ROW_W-1:0]  c0, c1, c2, kst;
  logic [ROW_W-1:0]  row_first, row_second;
  logic [2:0]        last_step;
  logic [TICK_W-1:0] gap;

  // which rows the current step opens
  always_comb begin
    sa  = d_q[ROW_W-1:SA_BITS];
    c0  = {sa, SA_BITS'(0)};
    c1  = {sa, SA_BITS'(1)};
    c2  = {sa, SA_BITS'(2)};
    kst = (op_q == OP_OR) ? {sa, SA_BITS'(ONES_OFS)} : {sa, SA_BITS'(ZERO_OFS)};
    last_step = (op_q == OP_COPY) ? 3'd0 : 3'd4;
    unique case (step_q)
      3'd0:    begin row_first = a_q; row_second = (op_q == OP_COPY) ? d_q : c0; end
      3'd1:    begin row_first = b_q; row_second = c1;  end
      3'd2:    begin row_first = kst; row_second = c2;  end
      3'd3:    begin row_first = c1;  row_second = c2;  end
      default: begin row_first = c0;  row_second = d_q; end
    endcase
    unique case (slot_q)
      2'd0:    gap = ras_q;
      2'd1:    gap = rp_q;
      default: gap = close_q;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    slot_d  = slot_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_CMD;
          step_d  = 3'd0;
          slot_d  = 2'd0;
        end
      end
      S_CMD, S_WAIT: begin
        if ((state_q == S_CMD && gap != '0) ) begin
          state_d = S_WAIT;
          cnt_d   = gap;
        end else if (state_q == S_WAIT && cnt_q != TICK_W'(1)) begin
          cnt_d = cnt_q - TICK_W'(1);
        end else if (slot_q != 2'd3) begin
          state_d = S_CMD;
          slot_d  = slot_q + 2'd1;
        end else if (step_q == last_step) begin
          state_d = S_DONE;
        end else begin
          state_d = S_CMD;
          step_d  = step_q + 3'd1;
          slot_d  = 2'd0;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      slot_q  <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      slot_q  <= slot_d;
      cnt_q   <= cnt_d;
      err_q   <= reject;
    end
  end

  // request capture, enabled by the accepted handshake
  always_ff @(posedge clk) begin
    if (start) begin
      op_q    <= op_e'(op_i);
      bank_q  <= bank_i;
      a_q     <= src_a_i;
      b_q     <= src_b_i;
      d_q     <= dst_i;
      ras_q   <= ras_i;
      rp_q    <= rp_i;
      close_q <= close_i;
    end
  end

  always_comb begin
    cmd_o    = CMD_NOP;
    cmd_bank = '0;
    cmd_row  = '0;
    if (state_q == S_CMD) begin
      cmd_bank = bank_q;
      unique case (slot_q)
        2'd0:    begin cmd_o = CMD_ACT; cmd_row = row_first;  end
        2'd2:    begin cmd_o = CMD_ACT; cmd_row = row_second; end
        default: cmd_o = CMD_PRE;
      endcase
    end
  end

  assign busy = (state_q != S_IDLE);
  assign done = (state_q == S_DONE);
  assign idle = (state_q == S_IDLE);
  assign err  = err_q;
endmodule

// File: rtl/imc_cmd_seq.sv
module imc_cmd_seq
  import imc_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 16,
  parameter int SA_ROWS   = 512,
  parameter int TICK_W    = 8,
  parameter int TBL_DEPTH = 8,
  localparam int SA_BITS   = $clog2(SA_ROWS),
  localparam int TBL_IDX_W = $clog2(TBL_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [ROW_W-1:0]     req_src_a,
  input  logic [ROW_W-1:0]     req_src_b,
  input  logic [ROW_W-1:0]     req_dst,
  input  logic [TICK_W-1:0]    cfg_ras_ticks,
  input  logic [TICK_W-1:0]    cfg_rp_ticks,
  input  logic [TICK_W-1:0]    cfg_close_ticks,
  input  logic                 tbl_we,
  input  logic [TBL_IDX_W-1:0] tbl_idx,
  input  logic [BANK_W-1:0]    tbl_bank,
  input  logic [ROW_W-1:0]     tbl_row,
  input  logic                 tbl_vld,
  output logic [1:0]           cmd_o,
  output logic [BANK_W-1:0]    cmd_bank,
  output logic [ROW_W-1:0]     cmd_row,
  output logic                 busy,
  output logic                 done,
  output logic                 err
);
  logic [NQ-1:0][ROW_W-1:0] q_rows;
  logic [NQ-1:0]            q_mask;
  logic                     shape_ok, tbl_hit, accept, idle;

  imc_req_check #(.ROW_W(ROW_W), .SA_BITS(SA_BITS)) chk_u (
    .op(req_op), .src_a(req_src_a), .src_b(req_src_b), .dst(req_dst),
    .q_rows(q_rows), .q_mask(q_mask), .shape_ok(shape_ok)
  );

  imc_badrow_tbl #(.BANK_W(BANK_W), .ROW_W(ROW_W), .DEPTH(TBL_DEPTH), .NQ(NQ)) tbl_u (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_bank(tbl_bank),
    .wr_row(tbl_row), .wr_vld(tbl_vld), .q_bank(req_bank), .q_rows(q_rows),
    .q_mask(q_mask), .hit(tbl_hit)
  );

  assign accept    = req_valid && idle;
  assign req_ready = idle;

  imc_seq_fsm #(.BANK_W(BANK_W), .ROW_W(ROW_W), .SA_BITS(SA_BITS), .TICK_W(TICK_W)) fsm_u (
    .clk(clk), .rst_n(rst_n),
    .start(accept && shape_ok && !tbl_hit),
    .reject(accept && !(shape_ok && !tbl_hit)),
    .op_i(req_op), .bank_i(req_bank), .src_a_i(req_src_a), .src_b_i(req_src_b),
    .dst_i(req_dst), .ras_i(cfg_ras_ticks), .rp_i(cfg_rp_ticks), .close_i(cfg_close_ticks),
    .cmd_o(cmd_o), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .busy(busy), .done(done), .err(err), .idle(idle)
  );
endmodule

// File: rtl/imc_cmd_seq_chk.sv
module imc_cmd_seq_chk #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [1:0]        cmd_o,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic              busy,
  input logic              done,
  input logic              err
);
  // R9
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  // R9
  no_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !req_ready);
  // R7
  reject_silent_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!busy && cmd_o == 2'd0));
  // R1
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd_o == 2'd0 && cmd_bank == '0 && cmd_row == '0));
  // R2
  first_act_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> cmd_o == 2'd1);
  // R2
  act_not_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'd1) |=> (cmd_o != 2'd1));
  // R1
  pre_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (cmd_o == 2'd2) |-> cmd_row == '0);
endmodule

bind imc_cmd_seq imc_cmd_seq_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_o(cmd_o), .cmd_bank(cmd_bank),
  .cmd_row(cmd_row), .busy(busy), .done(done), .err(err)
);

// File: tb/imc_cmd_seq_tb_top.sv
module imc_cmd_seq_tb_top;
  localparam int BW = 3;
  localparam int RW = 16;
  localparam int TW = 8;

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [1:0] req_op;
  logic [BW-1:0] req_bank;
  logic [RW-1:0] req_src_a, req_src_b, req_dst;
  logic [TW-1:0] cfg_ras_ticks, cfg_rp_ticks, cfg_close_ticks;
  logic tbl_we, tbl_vld;
  logic [2:0] tbl_idx;
  logic [BW-1:0] tbl_bank;
  logic [RW-1:0] tbl_row;
  logic [1:0] cmd_o;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic busy, done, err;

  imc_cmd_seq dut_i (.*);

  typedef struct {
    logic [1:0]    cmd;
    logic [BW-1:0] bank;
    logic [RW-1:0] row;
    bit            bsy;
    bit            dn;
    bit            er;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic push(logic [1:0] c, logic [BW-1:0] b, logic [RW-1:0] r,
                      bit bs, bit dn, bit er, string tag);
    exp_t e;
    e.cmd = c; e.bank = b; e.row = r; e.bsy = bs; e.dn = dn; e.er = er; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_gap(int n, string tag);
    for (int i = 0; i < n; i++) push(2'd0, '0, '0, 1, 0, 0, tag);
  endtask

  task automatic push_step(logic [BW-1:0] b, logic [RW-1:0] r1, logic [RW-1:0] r2,
                           int ras, int rp, int cl, string tag);
    push(2'd1, b, r1, 1, 0, 0, tag); push_gap(ras, tag);
    push(2'd2, b, '0, 1, 0, 0, tag); push_gap(rp, tag);
    push(2'd1, b, r2, 1, 0, 0, tag); push_gap(cl, tag);
    push(2'd2, b, '0, 1, 0, 0, tag); push_gap(cl, tag);
  endtask

  task automatic expect_op(int op, logic [BW-1:0] b, logic [RW-1:0] a, logic [RW-1:0] bb,
                           logic [RW-1:0] d, int ras, int rp, int cl, string tag);
    logic [RW-1:0] s;
    s = (d / 512) * 512;
    if (op == 0) push_step(b, a, d, ras, rp, cl, tag);
    else begin
      push_step(b, a, s + 0, ras, rp, cl, tag);
      push_step(b, bb, s + 1, ras, rp, cl, tag);
      push_step(b, (op == 2) ? s + 4 : s + 3, s + 2, ras, rp, cl, tag);
      push_step(b, s + 1, s + 2, ras, rp, cl, "R6");
      push_step(b, s + 0, d, ras, rp, cl, tag);
    end
    push(2'd0, '0, '0, 1, 1, 0, "R9");
  endtask

  task automatic drain();
    while (exp_q.size() > 0) begin @(negedge clk); #2; end
    @(negedge clk); #2;
  endtask

  task automatic send(int op, logic [BW-1:0] b, logic [RW-1:0] a, logic [RW-1:0] bb,
                      logic [RW-1:0] d, int ras, int rp, int cl, bit ok, string tag);
    @(negedge clk); #1;
    req_valid = 1; req_op = 2'(op); req_bank = b; req_src_a = a; req_src_b = bb; req_dst = d;
    cfg_ras_ticks = TW'(ras); cfg_rp_ticks = TW'(rp); cfg_close_ticks = TW'(cl);
    if (ok) expect_op(op, b, a, bb, d, ras, rp, cl, tag);
    else push(2'd0, '0, '0, 0, 0, 1, tag);
    @(negedge clk); #1;
    req_valid = 0;
  endtask

  task automatic tbl_write(int idx, logic [BW-1:0] b, logic [RW-1:0] r, bit v);
    @(negedge clk); #1;
    tbl_we = 1; tbl_idx = 3'(idx); tbl_bank = b; tbl_row = r; tbl_vld = v;
    @(negedge clk); #1;
    tbl_we = 0;
  endtask

  // cycle-by-cycle comparison against the reference trace
  always @(negedge clk) begin
    exp_t e;
    if (exp_q.size() > 0) e = exp_q.pop_front();
    else begin
      e.cmd = 2'd0; e.bank = '0; e.row = '0; e.bsy = 0; e.dn = 0; e.er = 0; e.tag = "R1";
    end
    n_chk++;
    if (cmd_o !== e.cmd || cmd_bank !== e.bank || cmd_row !== e.row || busy !== e.bsy ||
        done !== e.dn || err !== e.er || req_ready !== !e.bsy) begin
      n_fail++;
      $display("FAIL %s t=%0t: got cmd=%0d bank=%0d row=%0d busy=%0b done=%0b err=%0b rdy=%0b exp cmd=%0d bank=%0d row=%0d busy=%0b done=%0b err=%0b rdy=%0b",
               e.tag, $time, cmd_o, cmd_bank, cmd_row, busy, done, err, req_ready,
               e.cmd, e.bank, e.row, e.bsy, e.dn, e.er, !e.bsy);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  localparam logic [RW-1:0] SA5 = 16'd2560;
  localparam logic [RW-1:0] SA7 = 16'd3584;

  initial begin
    rst_n = 0; req_valid = 0; req_op = 0; req_bank = 0; req_src_a = 0; req_src_b = 0;
    req_dst = 0; cfg_ras_ticks = 0; cfg_rp_ticks = 0; cfg_close_ticks = 0;
    tbl_we = 0; tbl_idx = 0; tbl_bank = 0; tbl_row = 0; tbl_vld = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state is compared every idle cycle above

    // R2 copy with nonzero gaps
    send(0, 3'd2, SA5 + 40, 0, SA5 + 100, 3, 2, 4, 1, "R2");
    drain();
    // R3 zero gaps
    send(0, 3'd1, SA7 + 9, 0, SA7 + 200, 0, 0, 0, 1, "R3");
    drain();
    // R4 AND
    send(1, 3'd2, SA5 + 40, SA5 + 41, SA5 + 100, 2, 1, 3, 1, "R4");
    drain();
    // R5 OR
    send(2, 3'd6, SA7 + 50, SA7 + 51, SA7 + 60, 1, 2, 1, 1, "R5");
    drain();
    // R7 subarray mismatch on copy and on operand B
    send(0, 3'd2, SA7 + 40, 0, SA5 + 100, 3, 2, 4, 0, "R7");
    drain();
    send(1, 3'd2, SA5 + 40, SA7 + 41, SA5 + 100, 3, 2, 4, 0, "R7");
    drain();
    // R10 reserved op code
    send(3, 3'd2, SA5 + 40, SA5 + 41, SA5 + 100, 3, 2, 4, 0, "R10");
    drain();
    // R8 listed source row rejects; invalid entry ignored; other bank ignored
    tbl_write(0, 3'd2, SA5 + 40, 1);
    tbl_write(1, 3'd2, SA5 + 77, 0);
    drain();
    send(0, 3'd2, SA5 + 40, 0, SA5 + 100, 1, 1, 1, 0, "R8");
    drain();
    send(0, 3'd2, SA5 + 77, 0, SA5 + 100, 1, 1, 1, 1, "R8");
    drain();
    send(0, 3'd3, SA5 + 40, 0, SA5 + 100, 1, 1, 1, 1, "R8");
    drain();
    // R8 internal compute row and ones row
    tbl_write(0, 3'd4, SA7 + 1, 1);
    tbl_write(2, 3'd5, SA7 + 4, 1);
    drain();
    send(1, 3'd4, SA7 + 20, SA7 + 21, SA7 + 22, 1, 1, 1, 0, "R8");
    drain();
    send(2, 3'd5, SA7 + 20, SA7 + 21, SA7 + 22, 1, 1, 1, 0, "R8");
    drain();
    send(1, 3'd5, SA7 + 20, SA7 + 21, SA7 + 22, 1, 1, 1, 1, "R8");
    drain();
    // R9 / R3: offer a request and new gaps while busy; both must be ignored
    send(0, 3'd0, SA5 + 10, 0, SA5 + 11, 3, 2, 4, 1, "R3");
    #1;
    req_valid = 1; req_op = 2'd1; req_dst = SA7; cfg_ras_ticks = 0; cfg_rp_ticks = 0;
    cfg_close_ticks = 0;
    repeat (4) @(negedge clk);
    #1 req_valid = 0;
    drain();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule